// File: doc/BRIEF.md
# Crypto Bit-Manipulation Execution Unit

This block is the purely combinational datapath for the bit-manipulation operations that scalar cryptography code needs on a RISC-V style core. It has two operands of XLEN bits (32 or 64), a rotate amount that is either an immediate or comes from the second operand, and a 4-bit operation code. It returns one XLEN-bit result in the same cycle. The decoder, the register file and any pipeline registers sit outside.

The unit covers several operation groups. Bit permutations reverse the bits inside each byte, reverse the byte order, and interleave or de-interleave the two half-words of each 32-bit word. Pack operations place fields of the two operands side by side. Rotates come in full-width and 32-bit word forms. Inverted logic operations complete the set. Interleave and de-interleave use the same four masked swap stages, applied in opposite orders, so that one undoes the other.

Top module: `crypto_bitmanip_unit`

## Requirements
- R1: Code 0 reverses the bit order inside every byte of `src_a`: result bit 8k+j equals `src_a` bit 8k+7-j. Applying it twice gives back the operand.
- R2: Code 1 (interleave) works on each 32-bit word separately. Within a word, result bit 2i equals operand bit i and result bit 2i+1 equals operand bit 16+i, for i from 0 to 15.
- R3: Code 2 (de-interleave) is the inverse of code 1. Within each 32-bit word, result bit i equals operand bit 2i and result bit 16+i equals operand bit 2i+1. Interleave followed by de-interleave returns the operand.
- R4: Code 3 puts the low XLEN/2 bits of `src_a` in the low half of the result and the low XLEN/2 bits of `src_b` in the high half.
- R5: Code 4 puts `src_a[7:0]` in result bits 7:0 and `src_b[7:0]` in bits 15:8. All higher bits are zero.
- R6: Code 5 builds the 32-bit value {`src_b[15:0]`, `src_a[15:0]`} and sign-extends it from bit 31 to XLEN bits.
- R7: Code 6 rotates `src_a` left and code 7 rotates it right. The amount is `imm_amt` when `amt_from_imm` is 1. Otherwise it is the low log2(XLEN) bits of `src_b`, and higher bits of `src_b` have no effect.
- R8: Code 8 rotates the low 32 bits of `src_a` left and code 9 rotates them right, by the low 5 bits of the selected amount. The 32-bit result is sign-extended from bit 31 to XLEN bits.
- R9: Code 10 reverses the order of all bytes of `src_a`: result byte k equals operand byte XLEN/8-1-k.
- R10: Code 11 gives `src_a & ~src_b`, code 12 gives `src_a | ~src_b`, and code 13 gives `~(src_a ^ src_b)`.
- R11: Codes 14 and 15 drive a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand; supplies the rotate amount when no immediate is used |
| imm_amt | input | log2(XLEN) | Immediate rotate amount |
| amt_from_imm | input | 1 | Selects `imm_amt` as the rotate amount |
| result | output | XLEN | Operation result |

## Verification
Interleave and de-interleave are first driven with one-hot and alternating-bit operands, which show exactly where each bit is routed. They are then driven back to back with random operands, and the round trip must reproduce the input. This catches a swap stage that is missing or applied in the wrong order, even when a single pass happens to match. Rotates are tried with amounts of zero, one, the largest value, and random `src_b` whose upper bits are also random. Together these separate the two amount sources, show whether bits above the amount field are ignored, and expose the word-form sign extension. Operands with bit 31 set and clear decide whether the pack and word rotate forms extend the sign correctly.

// File: rtl/crypto_bitmanip_unit.sv
module crypto_bitmanip_unit #(
  parameter int XLEN = 64
) (
  input  logic [3:0]              op_sel,
  input  logic [XLEN-1:0]         src_a,
  input  logic [XLEN-1:0]         src_b,
  input  logic [$clog2(XLEN)-1:0] imm_amt,
  input  logic                    amt_from_imm,
  output logic [XLEN-1:0]         result
);
  localparam int AW = $clog2(XLEN);
  localparam int HW = XLEN / 2;
  localparam int NB = XLEN / 8;

  function automatic logic [XLEN-1:0] rep_mask(input logic [31:0] pat, input int w);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = pat[i % w];
    return m;
  endfunction

  function automatic logic [XLEN-1:0] swap_stage(input logic [XLEN-1:0] x,
                                                 input logic [XLEN-1:0] m, input int s);
    return ((x & m) << s) | ((x & ~m) >> s);
  endfunction

  function automatic logic [XLEN-1:0] shuf_stage(input logic [XLEN-1:0] x,
                                                 input logic [XLEN-1:0] l, input int s);
    logic [XLEN-1:0] r;
    r = l >> s;
    return (x & ~(l | r)) | ((x << s) & l) | ((x >> s) & r);
  endfunction

  localparam logic [XLEN-1:0] SW1 = rep_mask(32'h55, 8);
  localparam logic [XLEN-1:0] SW2 = rep_mask(32'h33, 8);
  localparam logic [XLEN-1:0] SW4 = rep_mask(32'h0f, 8);
  localparam logic [XLEN-1:0] SH1 = rep_mask(32'h44, 8);
  localparam logic [XLEN-1:0] SH2 = rep_mask(32'h30, 8);
  localparam logic [XLEN-1:0] SH4 = rep_mask(32'h0f00, 16);
  localparam logic [XLEN-1:0] SH8 = rep_mask(32'h00ff0000, 32);

  logic [AW-1:0]     amt;
  logic [XLEN-1:0]   brev, zip_v, unzip_v, rev_v, rol_v, ror_v;
  logic [2*XLEN-1:0] rol_w, ror_w;
  logic [63:0]       rolw_t, rorw_t;
  logic [31:0]       packw32, rolw32, rorw32;
  logic [XLEN-1:0]   packw_v, rolw_v, rorw_v;

  assign amt = amt_from_imm ? imm_amt : src_b[AW-1:0];

  assign brev    = swap_stage(swap_stage(swap_stage(src_a, SW1, 1), SW2, 2), SW4, 4);
  assign unzip_v = shuf_stage(shuf_stage(shuf_stage(shuf_stage(src_a, SH1, 1), SH2, 2), SH4, 4), SH8, 8);
  assign zip_v   = shuf_stage(shuf_stage(shuf_stage(shuf_stage(src_a, SH8, 8), SH4, 4), SH2, 2), SH1, 1);

  always_comb
    for (int k = 0; k < NB; k++) rev_v[8*k +: 8] = src_a[8*(NB-1-k) +: 8];

  assign rol_w = {src_a, src_a} << amt;
  assign ror_w = {src_a, src_a} >> amt;
  assign rol_v = rol_w[2*XLEN-1:XLEN];
  assign ror_v = ror_w[XLEN-1:0];

  assign rolw_t  = {src_a[31:0], src_a[31:0]} << amt[4:0];
  assign rorw_t  = {src_a[31:0], src_a[31:0]} >> amt[4:0];
  assign rolw32  = rolw_t[63:32];
  assign rorw32  = rorw_t[31:0];
  assign packw32 = {src_b[15:0], src_a[15:0]};

  generate
    if (XLEN > 32) begin : g_sext
      assign packw_v = {{(XLEN-32){packw32[31]}}, packw32};
      assign rolw_v  = {{(XLEN-32){rolw32[31]}}, rolw32};
      assign rorw_v  = {{(XLEN-32){rorw32[31]}}, rorw32};
    end else begin : g_nosext
      assign packw_v = packw32;
      assign rolw_v  = rolw32;
      assign rorw_v  = rorw32;
    end
  endgenerate

  always_comb begin
    case (op_sel)
      4'd0:    result = brev;
      4'd1:    result = zip_v;
      4'd2:    result = unzip_v;
      4'd3:    result = {src_b[HW-1:0], src_a[HW-1:0]};
      4'd4:    result = {{(XLEN-16){1'b0}}, src_b[7:0], src_a[7:0]};
      4'd5:    result = packw_v;
      4'd6:    result = rol_v;
      4'd7:    result = ror_v;
      4'd8:    result = rolw_v;
      4'd9:    result = rorw_v;
      4'd10:   result = rev_v;
      4'd11:   result = src_a & ~src_b;
      4'd12:   result = src_a | ~src_b;
      4'd13:   result = ~(src_a ^ src_b);
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/crypto_bitmanip_chk.sv
module crypto_bitmanip_chk #(
  parameter int XLEN = 64
) (
  input logic [3:0]      op_sel,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] result
);
  always_comb begin
    if (op_sel == 4'd0)
      AST_BREV_KEEPS_WEIGHT: assert ($countones(result) == $countones(src_a)) else $error("brev weight"); // R1
    if (op_sel == 4'd1 || op_sel == 4'd2)
      AST_SHUFFLE_KEEPS_WEIGHT: assert ($countones(result) == $countones(src_a)) else $error("shuffle weight"); // R2
    if (op_sel == 4'd4)
      AST_PACKH_UPPER_ZERO: assert (result[XLEN-1:16] == '0) else $error("packh upper"); // R5
    if (op_sel == 4'd6 || op_sel == 4'd7)
      AST_ROTATE_KEEPS_WEIGHT: assert ($countones(result) == $countones(src_a)) else $error("rotate weight"); // R7
    if (op_sel == 4'd10)
      AST_REV8_KEEPS_WEIGHT: assert ($countones(result) == $countones(src_a)) else $error("rev8 weight"); // R9
    if (op_sel == 4'd11)
      AST_ANDN_SUBSET: assert ((result & ~src_a) == '0) else $error("andn subset"); // R10
    if (op_sel == 4'd12)
      AST_ORN_SUPERSET: assert ((src_a & ~result) == '0) else $error("orn superset"); // R10
    if (op_sel >= 4'd14)
      AST_UNDEF_ZERO: assert (result == '0) else $error("undefined op"); // R11
  end

  generate
    if (XLEN > 32) begin : g_wchk
      always_comb
        if (op_sel == 4'd8 || op_sel == 4'd9)
          AST_WORD_ROT_SEXT: assert (result[XLEN-1:32] == {(XLEN-32){result[31]}}) else $error("word sext"); // R8
      always_comb
        if (op_sel == 4'd5)
          AST_PACKW_SEXT: assert (result[XLEN-1:32] == {(XLEN-32){result[31]}}) else $error("packw sext"); // R6
    end
  endgenerate
endmodule

bind crypto_bitmanip_unit crypto_bitmanip_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_crypto_bitmanip_unit.sv
module test_crypto_bitmanip_unit;
  localparam int W  = 64;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic [3:0]    op_sel;
  logic [W-1:0]  src_a, src_b, result;
  logic [AW-1:0] imm_amt;
  logic          amt_from_imm;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  crypto_bitmanip_unit #(.XLEN(W)) i_crypto_bitmanip_unit (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm_amt(imm_amt),
    .amt_from_imm(amt_from_imm), .result(result));

  function automatic logic [W-1:0] sx32(input logic [31:0] v);
    return {{(W-32){v[31]}}, v};
  endfunction

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [AW-1:0] im,
                                         input logic ui);
    logic [W-1:0] r;
    logic [31:0]  t;
    int n;
    r = '0;
    n = ui ? int'(im) : int'(b[AW-1:0]);
    case (op)
      4'd0: for (int i = 0; i < W; i++) r[i] = a[(i/8)*8 + 7 - i%8];
      4'd1: for (int w = 0; w < W/32; w++)
              for (int i = 0; i < 16; i++) begin
                r[w*32+2*i] = a[w*32+i]; r[w*32+2*i+1] = a[w*32+16+i];
              end
      4'd2: for (int w = 0; w < W/32; w++)
              for (int i = 0; i < 16; i++) begin
                r[w*32+i] = a[w*32+2*i]; r[w*32+16+i] = a[w*32+2*i+1];
              end
      4'd3: r = {b[W/2-1:0], a[W/2-1:0]};
      4'd4: r = {{(W-16){1'b0}}, b[7:0], a[7:0]};
      4'd5: r = sx32({b[15:0], a[15:0]});
      4'd6: for (int i = 0; i < W; i++) r[(i+n)%W] = a[i];
      4'd7: for (int i = 0; i < W; i++) r[i] = a[(i+n)%W];
      4'd8: begin for (int i = 0; i < 32; i++) t[(i+n)%32] = a[i]; r = sx32(t); end
      4'd9: begin for (int i = 0; i < 32; i++) t[i] = a[(i+n)%32]; r = sx32(t); end
      4'd10: for (int k = 0; k < W/8; k++) r[8*k +: 8] = a[8*(W/8-1-k) +: 8];
      4'd11: r = a & ~b;
      4'd12: r = a | ~b;
      4'd13: r = ~(a ^ b);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1"; 4'd1: return "R2"; 4'd2: return "R3"; 4'd3: return "R4";
      4'd4: return "R5"; 4'd5: return "R6"; 4'd6, 4'd7: return "R7";
      4'd8, 4'd9: return "R8"; 4'd10: return "R9"; 4'd11, 4'd12, 4'd13: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic compare(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h got=%h exp=%h", req, op_sel, src_a, src_b, result, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [AW-1:0] im, input logic ui);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; imm_amt = im; amt_from_imm = ui;
    #1;
    compare(tag(op), model(op, a, b, im, ui));
  endtask

  initial begin
    logic [W-1:0] x, y;
    void'($urandom(32'd1234));
    op_sel = 4'd15; src_a = '1; src_b = '1; imm_amt = '0; amt_from_imm = 1'b0;
    #1;
    compare("R11", '0);
    apply(4'd0, 64'h0123_4567_89ab_cdef, '0, '0, 0);           // R1
    apply(4'd1, 64'h0000_0001_0001_0000, '0, '0, 0);           // R2 one-hot
    apply(4'd1, 64'hffff_0000_0000_ffff, '0, '0, 0);           // R2
    apply(4'd2, 64'haaaa_aaaa_5555_5555, '0, '0, 0);           // R3 alternating
    apply(4'd3, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, '0, 0); // R4
    apply(4'd4, '1, '1, '0, 0);                                 // R5 upper zero
    apply(4'd5, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_8001, '0, 0); // R6 negative
    apply(4'd5, 64'hffff_ffff_ffff_1234, 64'hffff_ffff_ffff_7001, '0, 0); // R6 positive
    apply(4'd6, 64'h8000_0000_0000_0001, 64'hffff_ffff_ffff_ff00, '0, 0); // R7 zero amount, upper b ignored
    apply(4'd7, 64'h8000_0000_0000_0001, 64'd1, 6'd63, 1);     // R7 immediate 63
    apply(4'd8, 64'hdead_beef_4000_0000, 64'd33, '0, 0);       // R8 bit5 of amount ignored
    apply(4'd9, 64'h0000_0000_0000_0001, 64'd1, '0, 0);        // R8 sign set
    apply(4'd10, 64'h0011_2233_4455_6677, '0, '0, 0);          // R9
    apply(4'd11, 64'hf0f0, 64'hff00, '0, 0);                   // R10
    apply(4'd12, 64'hf0f0, 64'hff00, '0, 0);                   // R10
    apply(4'd13, 64'hf0f0, 64'hff00, '0, 0);                   // R10
    apply(4'd14, '1, '0, '0, 0);                               // R11

    for (int k = 0; k < 1500; k++)
      apply(4'($urandom_range(0, 15)), rnd64(), rnd64(), AW'($urandom()), 1'($urandom()));

    for (int k = 0; k < 200; k++) begin                         // R3 round trip
      x = rnd64();
      apply(4'd1, x, '0, '0, 0);
      y = result;
      apply(4'd2, y, '0, '0, 0);
      compare("R3", x);
      apply(4'd0, x, '0, '0, 0);                                // R1 involution
      y = result;
      apply(4'd0, y, '0, '0, 0);
      compare("R1", x);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired got=running exp=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule